// File: doc/BRIEF.md
# Packed Signed Greater-Than Comparator

This block compares two 512-bit operands lane by lane as two's-complement integers and reports, for every lane, whether the first operand is strictly larger than the second. The lane width is 8, 16 or 32 bits and is chosen per operation. The active width is 128, 256 or 512 bits. A wider operation is the same compare repeated over more lanes, so a 256-bit operation behaves as two independent 128-bit halves.

Two result forms are offered. The vector form fills each lane of a 512-bit destination with all ones or all zeros. Bits above the active width are either kept from an old destination value (legacy mode) or cleared. The mask form packs one bit per lane into a 64-bit mask. Bits can be zeroed by a writemask, and with 32-bit lanes the low dword of the second operand can be broadcast against every lane.

A caller presents the operands and controls with a one-cycle `start_i` pulse. The result is registered and appears one clock later, together with a one-cycle `done_o` strobe.

Top module: `pcmp_gt_unit`

## Requirements
- R1: Lanes are compared as signed two's-complement values with strict greater-than. Equal lanes give 0. `esz_i` selects the lane width: 0 gives 8 bits, 1 gives 16 bits, 2 and 3 give 32 bits.
- R2: In vector form (`form_mask_i`=0), each active lane of `vec_o` becomes all ones when the first operand is greater and all zeros otherwise.
- R3: In mask form (`form_mask_i`=1), `mask_o[j]` holds the result of lane j for j below the lane count. The lane count is the active width divided by the lane width. `vlen_i` selects the active width: 0 gives 128 bits, 1 gives 256 bits, 2 and 3 give 512 bits.
- R4: In mask form, mask bits from the lane count up to bit 63 are 0.
- R5: In mask form with `wm_en_i`=1, every mask bit whose `wmask_i` bit is 0 is 0. With `wm_en_i`=0, `wmask_i` has no effect.
- R6: In mask form with 32-bit lanes and `bcast_i`=1, bits 31:0 of `src_b_i` are compared against every lane. In any other case `bcast_i` has no effect.
- R7: In vector form with `zero_upper_i`=0 (legacy), only bits 127:0 are computed, bits 511:128 of `vec_o` take `old_dst_i[511:128]`, and `vlen_i` has no effect.
- R8: In vector form with `zero_upper_i`=1, lanes inside the active width are computed and all bits above it are 0. The mask form ignores `zero_upper_i`.
- R9: Inputs are sampled on `start_i`. The selected result register updates one clock later, while the other form's register holds its value. `done_o` is high exactly in the cycle after each `start_i`. Without `start_i`, both outputs hold.
- R10: A synchronous active-low reset clears `vec_o`, `mask_o` and `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request; all other inputs are sampled with it |
| esz_i | input | 2 | Lane width code |
| vlen_i | input | 2 | Active width code |
| form_mask_i | input | 1 | 1 selects mask form, 0 selects vector form |
| zero_upper_i | input | 1 | Vector form: 1 clears bits above the active width, 0 keeps the upper bits from the old value |
| wm_en_i | input | 1 | Enables writemask zeroing in mask form |
| wmask_i | input | 64 | Writemask, one bit per lane |
| bcast_i | input | 1 | Broadcast the low dword of the second operand (mask form, 32-bit lanes) |
| src_a_i | input | 512 | First operand |
| src_b_i | input | 512 | Second operand |
| old_dst_i | input | 512 | Previous destination value for legacy mode |
| vec_o | output | 512 | Vector-form result register |
| mask_o | output | 64 | Mask-form result register |
| done_o | output | 1 | One-cycle strobe when a result is written |

## Verification
The assertions check on every cycle the relations that need no arithmetic model:
- `done_o` follows `start_i` by one cycle.
- Both outputs hold while idle, and the mask holds during a vector-form operation.
- Legacy mode copies the old upper bits.
- 128-bit zero-upper operations clear the bits above 127.
- Writemask zeroing applies.
- Mask bits above 15 stay clear for 128-bit operations.

Only the bench's sweeps can show that the signed compare itself is right. It exercises the sign boundary, equal lanes, every combination of lane width and active width, and broadcast. It also shows that broadcast and the writemask have no effect when they do not apply.

// File: rtl/pcmp_pkg.sv
// Package: shared codes and helpers for the packed signed compare unit.
// Assumes a 512-bit datapath with a 128-bit legacy region.
package pcmp_pkg;

    typedef enum logic [1:0] {
        ESZ_B8  = 2'd0,
        ESZ_H16 = 2'd1,
        ESZ_W32 = 2'd2,
        ESZ_W32X = 2'd3
    } esz_e;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_512X = 2'd3
    } vlen_e;

    localparam int unsigned LEG_BYTES = 16;

    // Active width in bytes for a width code.
    function automatic logic [6:0] vl_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 7'd16;
            2'd1:    return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

    // log2 of lane width in bytes for a size code.
    function automatic logic [1:0] lane_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/pcmp_lane_cmp.sv
// Lane comparator: strict signed greater-than for every 8, 16 and 32-bit
// lane of the two operands, all widths in parallel.
// Assumes DATA_W is a multiple of 32.
module pcmp_lane_cmp #(
    parameter int unsigned DATA_W = 512
) (
    input  logic [DATA_W-1:0]    a_i,
    input  logic [DATA_W-1:0]    b_i,
    output logic [DATA_W/8-1:0]  gt8_o,
    output logic [DATA_W/16-1:0] gt16_o,
    output logic [DATA_W/32-1:0] gt32_o
);
    localparam int unsigned N8  = DATA_W / 8;
    localparam int unsigned N16 = DATA_W / 16;
    localparam int unsigned N32 = DATA_W / 32;

    for (genvar k = 0; k < N8; k++) begin : g_b8
        // byte lane signed compare
        assign gt8_o[k] = $signed(a_i[k*8 +: 8]) > $signed(b_i[k*8 +: 8]);
    end

    for (genvar k = 0; k < N16; k++) begin : g_h16
        // halfword lane signed compare
        assign gt16_o[k] = $signed(a_i[k*16 +: 16]) > $signed(b_i[k*16 +: 16]);
    end

    for (genvar k = 0; k < N32; k++) begin : g_w32
        // word lane signed compare
        assign gt32_o[k] = $signed(a_i[k*32 +: 32]) > $signed(b_i[k*32 +: 32]);
    end

endmodule

// File: rtl/pcmp_vec_pack.sv
// Vector packer: expands per-lane results into byte fills and applies the
// upper-region policy (keep old value in legacy mode, clear in zero-upper).
// Assumes DATA_W = 512 so that width codes map onto whole bytes.
module pcmp_vec_pack #(
    parameter int unsigned DATA_W = 512
) (
    input  logic [DATA_W/8-1:0]  gt8_i,
    input  logic [DATA_W/16-1:0] gt16_i,
    input  logic [DATA_W/32-1:0] gt32_i,
    input  logic [1:0]           esz_i,
    input  logic [1:0]           vlen_i,
    input  logic                 zero_upper_i,
    input  logic [DATA_W-1:0]    old_dst_i,
    output logic [DATA_W-1:0]    vec_o
);
    import pcmp_pkg::*;

    localparam int unsigned NB = DATA_W / 8;

    logic [6:0] act_bytes;

    // Number of bytes that receive compare results.
    always_comb begin
        act_bytes = zero_upper_i ? vl_bytes(vlen_i) : 7'(LEG_BYTES);
    end

    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic lane_bit;
        logic active;

        // Pick the lane result covering this byte and fill or pass through.
        always_comb begin
            case (esz_i)
                ESZ_B8:  lane_bit = gt8_i[k];
                ESZ_H16: lane_bit = gt16_i[k/2];
                default: lane_bit = gt32_i[k/4];
            endcase
            active = (7'(k) < act_bytes);
            if (active)
                vec_o[k*8 +: 8] = {8{lane_bit}};
            else if (zero_upper_i)
                vec_o[k*8 +: 8] = 8'h00;
            else
                vec_o[k*8 +: 8] = old_dst_i[k*8 +: 8];
        end
    end

endmodule

// File: rtl/pcmp_mask_pack.sv
// Mask packer: one bit per lane, zeroing writemask, clears bits at and
// above the active lane count. Assumes DATA_W = 512 (64 mask bits).
module pcmp_mask_pack #(
    parameter int unsigned DATA_W = 512
) (
    input  logic [DATA_W/8-1:0]  gt8_i,
    input  logic [DATA_W/16-1:0] gt16_i,
    input  logic [DATA_W/32-1:0] gt32_i,
    input  logic [1:0]           esz_i,
    input  logic [1:0]           vlen_i,
    input  logic                 wm_en_i,
    input  logic [DATA_W/8-1:0]  wmask_i,
    output logic [DATA_W/8-1:0]  mask_o
);
    import pcmp_pkg::*;

    localparam int unsigned MW = DATA_W / 8;

    logic [MW-1:0] sel_gt;
    logic [6:0]    lanes;

    // Select the lane vector for the size and derive the lane count.
    always_comb begin
        case (esz_i)
            ESZ_B8:  sel_gt = gt8_i;
            ESZ_H16: sel_gt = MW'(gt16_i);
            default: sel_gt = MW'(gt32_i);
        endcase
        lanes = vl_bytes(vlen_i) >> lane_shift(esz_i);
    end

    for (genvar j = 0; j < MW; j++) begin : g_bit
        // Gate each bit by lane range and writemask (zeroing only).
        always_comb begin
            mask_o[j] = (7'(j) < lanes) & sel_gt[j] & (~wm_en_i | wmask_i[j]);
        end
    end

endmodule

// File: rtl/pcmp_gt_unit.sv
// Top: packed signed greater-than unit. Samples operands on start_i,
// computes vector or mask form and registers the result with a done
// strobe one clock later. Assumes DATA_W = 512.
module pcmp_gt_unit #(
    parameter int unsigned DATA_W = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [1:0]          esz_i,
    input  logic [1:0]          vlen_i,
    input  logic                form_mask_i,
    input  logic                zero_upper_i,
    input  logic                wm_en_i,
    input  logic [DATA_W/8-1:0] wmask_i,
    input  logic                bcast_i,
    input  logic [DATA_W-1:0]   src_a_i,
    input  logic [DATA_W-1:0]   src_b_i,
    input  logic [DATA_W-1:0]   old_dst_i,
    output logic [DATA_W-1:0]   vec_o,
    output logic [DATA_W/8-1:0] mask_o,
    output logic                done_o
);
    localparam int unsigned MW  = DATA_W / 8;
    localparam int unsigned N16 = DATA_W / 16;
    localparam int unsigned N32 = DATA_W / 32;

    logic              use_bc;
    logic [DATA_W-1:0] b_eff;
    logic [MW-1:0]     gt8;
    logic [N16-1:0]    gt16;
    logic [N32-1:0]    gt32;
    logic [DATA_W-1:0] vec_n;
    logic [MW-1:0]     mask_n;
    logic [DATA_W-1:0] vec_q;
    logic [MW-1:0]     mask_q;
    logic              done_q;

    // Broadcast applies only to 32-bit lanes in mask form.
    always_comb begin
        use_bc = bcast_i & form_mask_i & esz_i[1];
    end

    for (genvar d = 0; d < N32; d++) begin : g_bc
        assign b_eff[d*32 +: 32] = use_bc ? src_b_i[31:0] : src_b_i[d*32 +: 32];
    end

    pcmp_lane_cmp #(.DATA_W(DATA_W)) cmp_i (
        .a_i    (src_a_i),
        .b_i    (b_eff),
        .gt8_o  (gt8),
        .gt16_o (gt16),
        .gt32_o (gt32)
    );

    pcmp_vec_pack #(.DATA_W(DATA_W)) vpack_i (
        .gt8_i        (gt8),
        .gt16_i       (gt16),
        .gt32_i       (gt32),
        .esz_i        (esz_i),
        .vlen_i       (vlen_i),
        .zero_upper_i (zero_upper_i),
        .old_dst_i    (old_dst_i),
        .vec_o        (vec_n)
    );

    pcmp_mask_pack #(.DATA_W(DATA_W)) mpack_i (
        .gt8_i   (gt8),
        .gt16_i  (gt16),
        .gt32_i  (gt32),
        .esz_i   (esz_i),
        .vlen_i  (vlen_i),
        .wm_en_i (wm_en_i),
        .wmask_i (wmask_i),
        .mask_o  (mask_n)
    );

    // Result registers: only the selected form is written on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            mask_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start_i;
            if (start_i && !form_mask_i)
                vec_q <= vec_n;
            if (start_i && form_mask_i)
                mask_q <= mask_n;
        end
    end

    assign vec_o  = vec_q;
    assign mask_o = mask_q;
    assign done_o = done_q;

endmodule

// File: rtl/pcmp_gt_unit_chk.sv
// Checker: cycle-level properties of the compare unit, bound to the top.
module pcmp_gt_unit_chk #(
    parameter int unsigned DATA_W = 512
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [1:0]          vlen_i,
    input logic                form_mask_i,
    input logic                zero_upper_i,
    input logic                wm_en_i,
    input logic [DATA_W/8-1:0] wmask_i,
    input logic [DATA_W-1:0]   old_dst_i,
    input logic [DATA_W-1:0]   vec_o,
    input logic [DATA_W/8-1:0] mask_o,
    input logic                done_o
);
    localparam int unsigned MW = DATA_W / 8;

    // R9
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(vec_o) && $stable(mask_o)));

    // R9
    mask_hold_on_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !form_mask_i) |=> $stable(mask_o));

    // R7
    legacy_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !form_mask_i && !zero_upper_i)
        |=> (vec_o[DATA_W-1:128] == $past(old_dst_i[DATA_W-1:128])));

    // R8
    zero_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !form_mask_i && zero_upper_i && vlen_i == 2'd0)
        |=> (vec_o[DATA_W-1:128] == '0));

    // R5
    wm_zeroing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && form_mask_i && wm_en_i)
        |=> ((mask_o & ~$past(wmask_i)) == '0));

    // R4
    mask_tail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && form_mask_i && vlen_i == 2'd0)
        |=> (mask_o[MW-1:16] == '0));

endmodule

bind pcmp_gt_unit pcmp_gt_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .vlen_i       (vlen_i),
    .form_mask_i  (form_mask_i),
    .zero_upper_i (zero_upper_i),
    .wm_en_i      (wm_en_i),
    .wmask_i      (wmask_i),
    .old_dst_i    (old_dst_i),
    .vec_o        (vec_o),
    .mask_o       (mask_o),
    .done_o       (done_o)
);

// File: tb/pcmp_gt_unit_tb_top.sv
// Bench: sweeps every size, width, form, mode, writemask and broadcast
// setting over several data patterns; expected values from arithmetic.
module pcmp_gt_unit_tb_top;

    localparam int DW = 512;
    localparam int MW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    esz_i = '0;
    logic [1:0]    vlen_i = '0;
    logic          form_mask_i = 1'b0;
    logic          zero_upper_i = 1'b0;
    logic          wm_en_i = 1'b0;
    logic [MW-1:0] wmask_i = '0;
    logic          bcast_i = 1'b0;
    logic [DW-1:0] src_a_i = '0;
    logic [DW-1:0] src_b_i = '0;
    logic [DW-1:0] old_dst_i = '0;
    logic [DW-1:0] vec_o;
    logic [MW-1:0] mask_o;
    logic          done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [DW-1:0] exp_vec = '0;
    logic [MW-1:0] exp_mask = '0;

    always #5 clk = ~clk;

    pcmp_gt_unit #(.DATA_W(DW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .esz_i        (esz_i),
        .vlen_i       (vlen_i),
        .form_mask_i  (form_mask_i),
        .zero_upper_i (zero_upper_i),
        .wm_en_i      (wm_en_i),
        .wmask_i      (wmask_i),
        .bcast_i      (bcast_i),
        .src_a_i      (src_a_i),
        .src_b_i      (src_b_i),
        .old_dst_i    (old_dst_i),
        .vec_o        (vec_o),
        .mask_o       (mask_o),
        .done_o       (done_o)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Signed value of a lane, by explicit two's-complement weighting.
    function automatic longint lane_val(input logic [DW-1:0] v, input int base, input int w);
        longint r = 0;
        for (int k = 0; k < w; k++)
            if (v[base+k]) r += longint'(1) << k;
        if (v[base+w-1]) r -= longint'(1) << w;
        return r;
    endfunction

    function automatic int lane_w(input logic [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    endfunction

    function automatic int width_bits(input logic [1:0] vl);
        return (vl == 2'd0) ? 128 : (vl == 2'd1) ? 256 : 512;
    endfunction

    function automatic logic [DW-1:0] model_vec(input logic [DW-1:0] a, input logic [DW-1:0] b,
            input logic [DW-1:0] old, input logic [1:0] sz, input logic [1:0] vl, input bit zu);
        logic [DW-1:0] r;
        int w = lane_w(sz);
        int lim = zu ? width_bits(vl) : 128;
        for (int l = 0; l < DW / w; l++) begin
            int base = l * w;
            for (int k = 0; k < w; k++) begin
                if (base < lim)
                    r[base+k] = (lane_val(a, base, w) > lane_val(b, base, w));
                else
                    r[base+k] = zu ? 1'b0 : old[base+k];
            end
        end
        return r;
    endfunction

    function automatic logic [MW-1:0] model_mask(input logic [DW-1:0] a, input logic [DW-1:0] b,
            input logic [1:0] sz, input logic [1:0] vl, input bit wm, input logic [MW-1:0] wmk,
            input bit bc);
        logic [MW-1:0] r = '0;
        int w = lane_w(sz);
        int lanes = width_bits(vl) / w;
        for (int j = 0; j < MW; j++) begin
            if (j < lanes) begin
                longint bv = (w == 32 && bc) ? lane_val(b, 0, 32) : lane_val(b, j * w, w);
                r[j] = (lane_val(a, j * w, w) > bv) && (!wm || wmk[j]);
            end
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] rand_wide();
        logic [DW-1:0] r;
        for (int k = 0; k < DW / 32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic run_op(input logic [1:0] sz, input logic [1:0] vl, input bit fm, input bit zu,
                          input bit wm, input bit bc, input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input string tag);
        logic [DW-1:0] old = rand_wide();
        logic [MW-1:0] wmk = {$urandom, $urandom};
        if (fm) exp_mask = model_mask(a, b, sz, vl, wm, wmk, bc);
        else    exp_vec  = model_vec(a, b, old, sz, vl, zu);
        @(negedge clk);
        start_i = 1'b1; esz_i = sz; vlen_i = vl; form_mask_i = fm; zero_upper_i = zu;
        wm_en_i = wm; wmask_i = wmk; bcast_i = bc; src_a_i = a; src_b_i = b; old_dst_i = old;
        @(negedge clk);
        start_i = 1'b0;
        src_a_i = ~a;
        old_dst_i = ~old;
        // R9: done one clock after start; R1 R2 R3 R5 R6 R7 R8 via the models
        check(done_o === 1'b1, {"R9 done ", tag}, DW'(done_o), DW'(1));
        check(vec_o === exp_vec, {"R2/R7/R8 vector ", tag}, vec_o, exp_vec);
        check(mask_o === exp_mask, {"R3/R4/R5/R6 mask ", tag}, DW'(mask_o), DW'(exp_mask));
        @(negedge clk);
        // R9: single-cycle strobe and hold while idle
        check(done_o === 1'b0, {"R9 strobe ", tag}, DW'(done_o), DW'(0));
        check(vec_o === exp_vec && mask_o === exp_mask, {"R9 hold ", tag}, vec_o, exp_vec);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] edge_b [5];
        edge_b[0] = 8'h80; edge_b[1] = 8'h7F; edge_b[2] = 8'h00;
        edge_b[3] = 8'hFF; edge_b[4] = 8'h01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(vec_o === '0, "R10 reset vec", vec_o, '0);
        check(mask_o === '0, "R10 reset mask", DW'(mask_o), '0);
        check(done_o === 1'b0, "R10 reset done", DW'(done_o), '0);
        rst_n = 1'b1;

        for (int pat = 0; pat < 4; pat++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int vl = 0; vl < 4; vl++) begin
                    for (int cfg = 0; cfg < 16; cfg++) begin
                        logic [DW-1:0] a;
                        logic [DW-1:0] b;
                        string tag;
                        case (pat)
                            0: begin a = rand_wide(); b = rand_wide(); end
                            1: begin // R1 sign-boundary bytes
                                for (int k = 0; k < MW; k++) begin
                                    a[k*8 +: 8] = edge_b[(k + cfg) % 5];
                                    b[k*8 +: 8] = edge_b[(k * 3 + 1) % 5];
                                end
                            end
                            2: begin a = rand_wide(); b = a; end // R1 equal gives 0
                            default: begin // R1 differ only in each dword sign bit
                                a = rand_wide();
                                b = a;
                                for (int d = 0; d < DW / 32; d++) b[d*32+31] = ~a[d*32+31];
                            end
                        endcase
                        tag = $sformatf("pat=%0d sz=%0d vl=%0d cfg=%0d", pat, sz, vl, cfg);
                        run_op(2'(sz), 2'(vl), cfg[0], cfg[1], cfg[2], cfg[3], a, b, tag);
                    end
                end
            end
        end

        // R10: reset during operation clears all outputs
        @(negedge clk);
        rst_n = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(vec_o === '0, "R10 mid reset vec", vec_o, '0);
        check(mask_o === '0, "R10 mid reset mask", DW'(mask_o), '0);
        check(done_o === 1'b0, "R10 mid reset done", DW'(done_o), '0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule